// File: doc/BRIEF.md
# Load/Store Address and Size Unit

This block sits beside an integer core and turns a load, store or cache-line flush instruction word into memory traffic. On acceptance it decodes the opcode, forms the effective address from a base register value plus either a sign-extended 16-bit offset or an index register value, and works out the access width. A transfer of one to four 32-bit words is then issued on a simple synchronous memory port, with one word per cycle.

For integer loads, the block selects the addressed byte lanes of the returned word, sign-extends the result and hands it to the integer register file. For integer stores, it replicates the source data across the lanes and drives matching byte enables. For floating-point transfers, it steps through consecutive floating-point register indices. It reads those registers for stores and writes them for loads. It also returns an updated base value when auto-increment is requested.

The core sees `busy` while a transfer is in flight and a one-cycle `done` at the end. A new instruction may be offered in the same cycle that `done` is high. Memory is little-endian. Read data returns one cycle after the request.

Top module: `lsu_addr_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `done`, `mem_req`, `rf_we`, `fp_we` and `base_we` are all low.
- R2: Integer loads with an immediate offset use opcode 0x01 (byte) and opcode 0x05. For opcode 0x05, instruction bit 0 picks 32-bit (1) or 16-bit (0). The address is base plus the sign-extended bits 15:0 with bit 0 cleared (16-bit) or bits 1:0 cleared (32-bit).
- R3: Integer loads with an index register use opcode 0x00 (byte) and opcode 0x04 (bit 0 picks the width as in R2). The address is base plus index.
- R4: Byte and 16-bit loaded values are sign-extended to 32 bits. Lanes are little-endian: a byte comes from bits 8*a+7:8*a of the returned word, where a is address bits 1:0. A 16-bit value comes from bits 31:16 when address bit 1 is set, and from bits 15:0 otherwise. The value is written to the register named by bits 20:16.
- R5: Integer stores use opcode 0x03 (byte) and opcode 0x07. The offset is formed from bits 20:16 as its upper five bits and bits 10:0 as its lower eleven. In opcode 0x07, offset bit 0 picks 32-bit (1) or 16-bit (0), and the low size bits are cleared before sign extension. Write data is `store_val`, replicated across lanes. Byte enables are one-hot at lane a for bytes, 0b1100 or 0b0011 for 16-bit (by address bit 1), and 0b1111 for words.
- R6: Floating-point transfers use opcodes 0x08 and 0x09 (load) and 0x0A and 0x0B (store). Odd opcodes add the sign-extended bits 15:0 with the size bits cleared; even opcodes add the index. Bits 2:0 are flags: bit 1 set means one word, otherwise bit 2 set means four words, otherwise two words. Word k goes to address EA+4k and to register (bits 20:16 rounded down to a multiple of the word count)+k.
- R7: When floating-point flag bit 0 is set, `base_we` pulses once, in the cycle after acceptance. `base_waddr` is bits 25:21 and `base_wdata` is the effective address.
- R8: Opcode 0x0D (line flush) makes no memory request and raises `done` in the cycle after acceptance. If the split offset's bit 0 is set, it also writes base plus the sign-extended split offset with bits 4:0 cleared back to the base register in that cycle.
- R9: An instruction is accepted on a clock edge where `issue_valid` is high and `busy` is low. The first request appears in the next cycle, and requests then advance by 4 bytes each cycle. A load's write-back appears one cycle after its request. `done` pulses for one cycle, one cycle after the last request (stores) or the last write-back (loads). `busy` is low in that cycle.
- R10: Opcodes outside those named in R2, R3, R5, R6 and R8 are ignored: no request, no write, no `done`, and `busy` stays low.
- R11: An instruction offered while `busy` is high is ignored and produces no memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Instruction offered this cycle |
| issue_insn | input | 32 | Instruction word |
| base_val | input | 32 | Value of the base register (bits 25:21) |
| index_val | input | 32 | Value of the index register (bits 15:11) |
| store_val | input | 32 | Integer store data (register in bits 15:11) |
| busy | output | 1 | Transfer in flight |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | 0 byte, 1 half, 2 word |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| rf_we | output | 1 | Integer register write |
| rf_waddr | output | 5 | Integer destination |
| rf_wdata | output | 32 | Extended load value |
| fp_rd_idx | output | 5 | Floating-point register read for stores |
| fp_rd_data | input | 32 | Contents of `fp_rd_idx` |
| fp_we | output | 1 | Floating-point register write |
| fp_waddr | output | 5 | Floating-point destination |
| fp_wdata | output | 32 | Loaded word |
| base_we | output | 1 | Base register update |
| base_waddr | output | 5 | Base register index |
| base_wdata | output | 32 | New base value |

## Verification
Two pairs of events can land in the same cycle. First, the `done` pulse of one transfer can coincide with the acceptance of the next. Second, the base auto-increment write can coincide with the first memory request of the same floating-point transfer. The bench provokes both by issuing every instruction as soon as `busy` drops, and by using auto-increment on multi-word transfers. A scoreboard of separate queues holds the memory, integer, floating-point and base events in their expected order. Any swapped, lost or extra event then shows up as a mismatch or as an unexpected event.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;
    localparam int XW     = 32;
    localparam int RIDX_W = 5;
    localparam int LANES  = XW / 8;
    localparam int MAXW   = 4;
    localparam int CNT_W  = $clog2(MAXW);
    localparam int NW_W   = CNT_W + 1;

    typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2} size_e;
    typedef enum logic [1:0] {K_NONE, K_INT, K_FP, K_FLUSH} kind_e;
    typedef enum logic [1:0] {S_IDLE, S_ACT, S_DRAIN} st_e;

    typedef struct packed {
        logic              valid;
        kind_e             kind;
        logic              store;
        size_e             size;
        logic [NW_W-1:0]   nwords;
        logic [XW-1:0]     ea;
        logic              autoinc;
        logic [XW-1:0]     base_new;
        logic [RIDX_W-1:0] reg_idx;
        logic [RIDX_W-1:0] base_idx;
    } dec_t;

    function automatic logic [XW-1:0] sx16(input logic [15:0] v);
        return {{(XW-16){v[15]}}, v};
    endfunction

    function automatic logic [15:0] size_mask(input size_e s);
        case (s)
            SZ_B:    return 16'hFFFF;
            SZ_H:    return 16'hFFFE;
            default: return 16'hFFFC;
        endcase
    endfunction
endpackage

// File: rtl/lsu_decode.sv
`timescale 1ns/1ps
module lsu_decode
    import lsu_pkg::*;
(
    input  logic [31:0]   insn,
    input  logic [XW-1:0] base_val,
    input  logic [XW-1:0] index_val,
    output dec_t          dec
);
    logic [5:0]  op;
    logic [15:0] imm;
    logic [15:0] split;
    logic [15:0] fmask;
    logic [2:0]  fl;

    always_comb begin
        op    = insn[31:26];
        imm   = insn[15:0];
        split = {insn[20:16], insn[10:0]};
        fl    = insn[2:0];
        fmask = 16'hFFFF;
        dec   = '0;
        dec.base_idx = insn[25:21];
        dec.nwords   = NW_W'(1);
        dec.size     = SZ_W;
        case (op)
            6'h00, 6'h01, 6'h04, 6'h05: begin
                dec.valid   = 1'b1;
                dec.kind    = K_INT;
                dec.reg_idx = insn[20:16];
                dec.size    = !op[2] ? SZ_B : (insn[0] ? SZ_W : SZ_H);
                dec.ea      = op[0] ? base_val + sx16(imm & size_mask(dec.size))
                                    : base_val + index_val;
            end
            6'h03, 6'h07: begin
                dec.valid   = 1'b1;
                dec.kind    = K_INT;
                dec.store   = 1'b1;
                dec.reg_idx = insn[15:11];
                dec.size    = !op[2] ? SZ_B : (split[0] ? SZ_W : SZ_H);
                dec.ea      = base_val + sx16(split & size_mask(dec.size));
            end
            6'h08, 6'h09, 6'h0A, 6'h0B: begin
                dec.valid   = 1'b1;
                dec.kind    = K_FP;
                dec.store   = op[1];
                dec.nwords  = fl[1] ? NW_W'(1) : (fl[2] ? NW_W'(4) : NW_W'(2));
                fmask       = ~(16'({dec.nwords, 2'b00}) - 16'd1);
                dec.ea      = op[0] ? base_val + sx16(imm & fmask)
                                    : base_val + index_val;
                dec.autoinc = fl[0];
                dec.base_new = dec.ea;
                dec.reg_idx = insn[20:16] & ~(RIDX_W'(dec.nwords) - RIDX_W'(1));
            end
            6'h0D: begin
                dec.valid    = 1'b1;
                dec.kind     = K_FLUSH;
                dec.autoinc  = split[0];
                dec.base_new = base_val + sx16(split & 16'hFFE0);
                dec.ea       = dec.base_new;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lsu_lanes.sv
`timescale 1ns/1ps
module lsu_lanes
    import lsu_pkg::*;
(
    input  size_e            st_size,
    input  logic [1:0]       st_lane,
    input  logic [XW-1:0]    st_data,
    output logic [LANES-1:0] st_be,
    output logic [XW-1:0]    st_wdata,
    input  size_e            ld_size,
    input  logic [1:0]       ld_lane,
    input  logic [XW-1:0]    ld_word,
    output logic [XW-1:0]    ld_ext
);
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    always_comb begin
        case (st_size)
            SZ_B: begin
                st_be    = LANES'(1) << st_lane;
                st_wdata = {LANES{st_data[7:0]}};
            end
            SZ_H: begin
                st_be    = st_lane[1] ? 4'b1100 : 4'b0011;
                st_wdata = {(LANES/2){st_data[15:0]}};
            end
            default: begin
                st_be    = '1;
                st_wdata = st_data;
            end
        endcase

        case (ld_lane)
            2'd0:    byte_sel = ld_word[7:0];
            2'd1:    byte_sel = ld_word[15:8];
            2'd2:    byte_sel = ld_word[23:16];
            default: byte_sel = ld_word[31:24];
        endcase
        half_sel = ld_lane[1] ? ld_word[31:16] : ld_word[15:0];
        case (ld_size)
            SZ_B:    ld_ext = {{(XW-8){byte_sel[7]}}, byte_sel};
            SZ_H:    ld_ext = {{(XW-16){half_sel[15]}}, half_sel};
            default: ld_ext = ld_word;
        endcase
    end
endmodule

// File: rtl/lsu_addr_unit.sv
`timescale 1ns/1ps
module lsu_addr_unit
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [31:0]       issue_insn,
    input  logic [XW-1:0]     base_val,
    input  logic [XW-1:0]     index_val,
    input  logic [XW-1:0]     store_val,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [XW-1:0]     mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [XW-1:0]     mem_wdata,
    input  logic [XW-1:0]     mem_rdata,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [XW-1:0]     rf_wdata,
    output logic [RIDX_W-1:0] fp_rd_idx,
    input  logic [XW-1:0]     fp_rd_data,
    output logic              fp_we,
    output logic [RIDX_W-1:0] fp_waddr,
    output logic [XW-1:0]     fp_wdata,
    output logic              base_we,
    output logic [RIDX_W-1:0] base_waddr,
    output logic [XW-1:0]     base_wdata
);
    typedef struct packed {
        st_e               st;
        kind_e             kind;
        logic              store;
        size_e             size;
        logic [NW_W-1:0]   nwords;
        logic [CNT_W-1:0]  cnt;
        logic [XW-1:0]     ea;
        logic [RIDX_W-1:0] reg_idx;
        logic [XW-1:0]     sdata;
        logic              pend;
        logic              pend_fp;
        logic [RIDX_W-1:0] pend_idx;
        logic [1:0]        pend_lane;
        size_e             pend_size;
        logic              base_we;
        logic [RIDX_W-1:0] base_idx;
        logic [XW-1:0]     base_data;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    dec_t dec;
    logic accept, last_word;
    logic [XW-1:0] ld_ext;

    lsu_decode u_dec (
        .insn      (issue_insn),
        .base_val  (base_val),
        .index_val (index_val),
        .dec       (dec)
    );

    lsu_lanes u_lanes (
        .st_size  (ctl_q.size),
        .st_lane  (mem_addr[1:0]),
        .st_data  ((ctl_q.kind == K_FP) ? fp_rd_data : ctl_q.sdata),
        .st_be    (mem_be),
        .st_wdata (mem_wdata),
        .ld_size  (ctl_q.pend_size),
        .ld_lane  (ctl_q.pend_lane),
        .ld_word  (mem_rdata),
        .ld_ext   (ld_ext)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.pend    = 1'b0;
        ctl_d.base_we = 1'b0;
        ctl_d.done    = 1'b0;
        accept    = issue_valid && (ctl_q.st == S_IDLE) && dec.valid;
        last_word = (NW_W'(ctl_q.cnt) == ctl_q.nwords - NW_W'(1));
        case (ctl_q.st)
            S_IDLE: if (accept) begin
                ctl_d.base_we   = dec.autoinc;
                ctl_d.base_idx  = dec.base_idx;
                ctl_d.base_data = dec.base_new;
                if (dec.kind == K_FLUSH) begin
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.st      = S_ACT;
                    ctl_d.kind    = dec.kind;
                    ctl_d.store   = dec.store;
                    ctl_d.size    = dec.size;
                    ctl_d.nwords  = dec.nwords;
                    ctl_d.cnt     = '0;
                    ctl_d.ea      = dec.ea;
                    ctl_d.reg_idx = dec.reg_idx;
                    ctl_d.sdata   = store_val;
                end
            end
            S_ACT: begin
                if (!ctl_q.store) begin
                    ctl_d.pend      = 1'b1;
                    ctl_d.pend_fp   = (ctl_q.kind == K_FP);
                    ctl_d.pend_idx  = ctl_q.reg_idx + RIDX_W'(ctl_q.cnt);
                    ctl_d.pend_lane = ctl_q.ea[1:0];
                    ctl_d.pend_size = ctl_q.size;
                end
                if (last_word) begin
                    ctl_d.st   = ctl_q.store ? S_IDLE : S_DRAIN;
                    ctl_d.done = ctl_q.store;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                end
            end
            default: begin
                ctl_d.st   = S_IDLE;
                ctl_d.done = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy       = (ctl_q.st != S_IDLE);
    assign done       = ctl_q.done;
    assign mem_req    = (ctl_q.st == S_ACT);
    assign mem_we     = ctl_q.store;
    assign mem_size   = ctl_q.size;
    assign mem_addr   = ctl_q.ea + XW'({ctl_q.cnt, 2'b00});
    assign fp_rd_idx  = ctl_q.reg_idx + RIDX_W'(ctl_q.cnt);
    assign rf_we      = ctl_q.pend && !ctl_q.pend_fp;
    assign rf_waddr   = ctl_q.pend_idx;
    assign rf_wdata   = ld_ext;
    assign fp_we      = ctl_q.pend && ctl_q.pend_fp;
    assign fp_waddr   = ctl_q.pend_idx;
    assign fp_wdata   = mem_rdata;
    assign base_we    = ctl_q.base_we;
    assign base_waddr = ctl_q.base_idx;
    assign base_wdata = ctl_q.base_data;

    a_r6_word_stride: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && $past(mem_req) |-> mem_addr == $past(mem_addr) + XW'(4));

    a_r9_wb_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || fp_we) |-> $past(mem_req && !mem_we));

    a_r7_base_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |-> $past(issue_valid && !busy));

    a_r5_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_size == 2'd0 |-> $countones(mem_be) == 1);

    a_r9_done_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !mem_req);
endmodule

// File: tb/lsu_addr_unit_tb.sv
`timescale 1ns/1ps
module lsu_addr_unit_tb;
    logic clk = 0, rst_n = 0;
    logic issue_valid = 0;
    logic [31:0] issue_insn = 0, base_val = 0, index_val = 0, store_val = 0;
    logic busy, done, mem_req, mem_we, rf_we, fp_we, base_we;
    logic [1:0] mem_size;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_wdata, fp_wdata, base_wdata, fp_rd_data;
    logic [3:0] mem_be;
    logic [4:0] rf_waddr, fp_rd_idx, fp_waddr, base_waddr;

    always #5 clk = ~clk;

    lsu_addr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_insn(issue_insn),
        .base_val(base_val), .index_val(index_val), .store_val(store_val),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_size(mem_size), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .fp_rd_idx(fp_rd_idx),
        .fp_rd_data(fp_rd_data), .fp_we(fp_we), .fp_waddr(fp_waddr),
        .fp_wdata(fp_wdata), .base_we(base_we), .base_waddr(base_waddr),
        .base_wdata(base_wdata)
    );

    logic [31:0] bmem [0:255];
    logic [31:0] fpr  [0:31];
    int checks = 0, errors = 0, done_seen = 0, done_exp = 0;

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  be;
        logic        we;
        string       tag;
    } ev_t;
    ev_t mq[$], rq[$], fq[$], bq[$];

    initial begin
        for (int i = 0; i < 256; i++)
            bmem[i] = {8'hF0 ^ 8'(i), 8'h12 + 8'(i), 8'h8C ^ 8'(i), 8'(i)};
        for (int i = 0; i < 32; i++)
            fpr[i] = 32'hA500_0000 | (32'(i) * 32'h111);
    end
    assign fp_rd_data = fpr[fp_rd_idx];

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) bmem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= bmem[mem_addr[9:2]];
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic unexpected(input string what, input logic [31:0] act);
        checks++;
        errors++;
        $display("FAIL R10/R11 unexpected %s act=%h exp=none", what, act);
    endtask

    // Scoreboard monitor, samples mid-cycle
    always @(negedge clk) begin : mon
        ev_t e;
        if (rst_n) begin
            if (done) done_seen++;
            if (mem_req) begin
                if (mq.size() == 0) unexpected("memory request", mem_addr);
                else begin
                    e = mq.pop_front();
                    chk(e.tag, "mem_addr", mem_addr, e.a);
                    chk(e.tag, "mem_we", 32'(mem_we), 32'(e.we));
                    chk(e.tag, "mem_be", 32'(mem_be), 32'(e.be));
                    if (e.we) chk(e.tag, "mem_wdata", mem_wdata, e.d);
                end
            end
            if (rf_we) begin
                if (rq.size() == 0) unexpected("rf write", rf_wdata);
                else begin
                    e = rq.pop_front();
                    chk(e.tag, "rf_waddr", 32'(rf_waddr), e.a);
                    chk(e.tag, "rf_wdata", rf_wdata, e.d);
                end
            end
            if (fp_we) begin
                if (fq.size() == 0) unexpected("fp write", fp_wdata);
                else begin
                    e = fq.pop_front();
                    chk(e.tag, "fp_waddr", 32'(fp_waddr), e.a);
                    chk(e.tag, "fp_wdata", fp_wdata, e.d);
                end
            end
            if (base_we) begin
                if (bq.size() == 0) unexpected("base write", base_wdata);
                else begin
                    e = bq.pop_front();
                    chk(e.tag, "base_waddr", 32'(base_waddr), e.a);
                    chk(e.tag, "base_wdata", base_wdata, e.d);
                end
            end
        end
    end

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] pick(input logic [31:0] w, input logic [1:0] lane, input int sz);
        logic [7:0] b;
        logic [15:0] h;
        b = w[8*lane +: 8];
        h = lane[1] ? w[31:16] : w[15:0];
        if (sz == 0) return {{24{b[7]}}, b};
        if (sz == 1) return sx(h);
        return w;
    endfunction

    function automatic logic [3:0] be_of(input logic [1:0] lane, input int sz);
        if (sz == 0) return 4'b0001 << lane;
        if (sz == 1) return lane[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [15:0] szmask(input int sz);
        return (sz == 2) ? 16'hFFFC : (sz == 1) ? 16'hFFFE : 16'hFFFF;
    endfunction

    task automatic push(inout ev_t q[$], input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, input logic we, input string tag);
        ev_t e;
        e.a = a; e.d = d; e.be = be; e.we = we; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wait_idle();
        @(posedge clk); #1;
        while (busy) begin @(posedge clk); #1; end
    endtask

    task automatic drive(input logic [31:0] insn, input logic [31:0] b, input logic [31:0] x, input logic [31:0] s);
        issue_valid = 1; issue_insn = insn; base_val = b; index_val = x; store_val = s;
        @(posedge clk); #1;
        issue_valid = 0;
    endtask

    // R2 (immediate) / R3 (indexed) integer loads, R4 extension
    task automatic t_ld(input bit indexed, input int sz, input logic [4:0] dst,
                        input logic [31:0] b, input logic [15:0] imm, input logic [31:0] x, input string tag);
        logic [31:0] ea, insn;
        logic [15:0] f;
        logic [5:0] op;
        wait_idle();
        if (indexed) begin
            op = (sz == 0) ? 6'h00 : 6'h04;
            ea = b + x;
            insn = {op, 5'd3, dst, 5'd4, 10'd0, (sz == 2)};
        end else begin
            op = (sz == 0) ? 6'h01 : 6'h05;
            f = (sz == 2) ? (imm | 16'h1) : (sz == 1) ? (imm & 16'hFFFE) : imm;
            ea = b + sx(f & szmask(sz));
            insn = {op, 5'd3, dst, f};
        end
        push(mq, ea, 0, be_of(ea[1:0], sz), 0, tag);
        push(rq, 32'(dst), pick(bmem[ea[9:2]], ea[1:0], sz), 0, 0, {tag, "/R4"});
        done_exp++;
        drive(insn, b, x, 32'h0);
    endtask

    // R5 integer stores with split offset
    task automatic t_st(input int sz, input logic [31:0] b, input logic [15:0] off,
                        input logic [31:0] data, input string tag);
        logic [31:0] ea, insn, wd;
        logic [15:0] f;
        wait_idle();
        f = (sz == 2) ? (off | 16'h1) : (sz == 1) ? (off & 16'hFFFE) : off;
        ea = b + sx(f & szmask(sz));
        insn = {((sz == 0) ? 6'h03 : 6'h07), 5'd6, f[15:11], 5'd7, f[10:0]};
        wd = (sz == 0) ? {4{data[7:0]}} : (sz == 1) ? {2{data[15:0]}} : data;
        push(mq, ea, wd, be_of(ea[1:0], sz), 1, tag);
        done_exp++;
        drive(insn, b, 32'h0, data);
    endtask

    // R6 floating-point transfers, R7 auto-increment
    task automatic t_fp(input bit st, input bit indexed, input logic [2:0] fl, input logic [4:0] dst,
                        input logic [31:0] b, input logic [15:0] imm, input logic [31:0] x, input string tag);
        logic [31:0] ea, insn, a;
        logic [15:0] f;
        logic [4:0] r0;
        int n;
        wait_idle();
        n = fl[1] ? 1 : (fl[2] ? 4 : 2);
        if (indexed) begin
            ea = b + x;
            insn = {(st ? 6'h0A : 6'h08), 5'd8, dst, 5'd9, 8'd0, fl};
        end else begin
            f = {imm[15:3], fl};
            ea = b + sx(f & ~(16'(4 * n) - 16'd1));
            insn = {(st ? 6'h0B : 6'h09), 5'd8, dst, f};
        end
        r0 = dst & ~(5'(n) - 5'd1);
        if (fl[0]) push(bq, 32'd8, ea, 0, 0, "R7");
        for (int k = 0; k < n; k++) begin
            a = ea + 32'(4 * k);
            push(mq, a, st ? fpr[r0 + 5'(k)] : 32'h0, 4'hF, st, tag);
            if (!st) push(fq, 32'(r0 + 5'(k)), bmem[a[9:2]], 0, 0, tag);
        end
        done_exp++;
        drive(insn, b, x, 32'h0);
    endtask

    // R8 line flush
    task automatic t_flush(input logic [31:0] b, input logic [15:0] off);
        wait_idle();
        if (off[0]) push(bq, 32'd12, b + sx(off & 16'hFFE0), 0, 0, "R8");
        done_exp++;
        drive({6'h0D, 5'd12, off[15:11], 5'd0, off[10:0]}, b, 32'h0, 32'h0);
        #3;
        chk("R8", "done after flush", 32'(done), 32'd1);
        chk("R8", "no request on flush", 32'(mem_req), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog expired act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] ea;
        // R1 reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1", "busy/done/req in reset", {26'd0, busy, done, mem_req, rf_we, fp_we, base_we}, 32'd0);
        end
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk("R1", "outputs after reset", {26'd0, busy, done, mem_req, rf_we, fp_we, base_we}, 32'd0);

        // R2 immediate loads: byte negative offset, half upper lane, word with masked bits
        t_ld(0, 0, 5'd5, 32'h100, 16'hFFFD, 0, "R2");
        t_ld(0, 1, 5'd6, 32'h200, 16'h0006, 0, "R2");
        t_ld(0, 2, 5'd7, 32'h200, 16'h000B, 0, "R2");
        t_ld(0, 1, 5'd9, 32'h240, 16'hFFFC, 0, "R2");
        // R3 indexed loads
        t_ld(1, 0, 5'd10, 32'h300, 0, 32'h7, "R3");
        t_ld(1, 2, 5'd11, 32'h300, 0, 32'h14, "R3");
        t_ld(1, 1, 5'd12, 32'h280, 0, 32'h2, "R3");

        // R5 stores, then read back through loads
        t_st(0, 32'h101, 16'hFFFF, 32'h0000_00C3, "R5");
        t_ld(0, 0, 5'd13, 32'h100, 16'h0000, 0, "R5");
        t_st(1, 32'h140, 16'h0012, 32'h0000_9ABC, "R5");
        t_ld(0, 1, 5'd14, 32'h150, 16'h0002, 0, "R5");
        t_st(2, 32'h160, 16'h0021, 32'h1234_5678, "R5");
        t_ld(1, 2, 5'd15, 32'h160, 0, 32'h20, "R5");

        // R6 / R7 floating point
        t_fp(0, 0, 3'b010, 5'd3, 32'h180, 16'h0010, 0, "R6");
        t_fp(0, 0, 3'b001, 5'd7, 32'h180, 16'h0020, 0, "R6");
        t_fp(0, 1, 3'b100, 5'd13, 32'h200, 0, 32'h40, "R6");
        t_fp(1, 0, 3'b000, 5'd5, 32'h380, 16'h0008, 0, "R6");
        t_fp(1, 0, 3'b101, 5'd22, 32'h300, 16'hFFF0, 0, "R6");
        t_fp(0, 1, 3'b011, 5'd1, 32'h3A0, 0, 32'hC, "R6");
        t_ld(0, 2, 5'd16, 32'h380, 16'h0004, 0, "R6");

        // R8 flush, with and without auto-increment
        t_flush(32'h1000, 16'h0041);
        t_flush(32'h1000, 16'hFFA0);

        // R9 cycle timing of a single byte load
        wait_idle();
        ea = 32'h0C5;
        push(mq, ea, 0, be_of(ea[1:0], 0), 0, "R9");
        push(rq, 32'd17, pick(bmem[ea[9:2]], ea[1:0], 0), 0, 0, "R9");
        done_exp++;
        drive({6'h01, 5'd3, 5'd17, 16'h00C5}, 32'h0, 32'h0, 32'h0);
        @(negedge clk); chk("R9", "request one cycle after accept", 32'(mem_req), 32'd1);
        @(negedge clk); chk("R9", "write-back after request", 32'(rf_we), 32'd1);
        @(negedge clk); chk("R9", "done pulse", 32'(done), 32'd1);
        chk("R9", "busy low with done", 32'(busy), 32'd0);

        // R10 unknown opcode ignored
        wait_idle();
        drive({6'h3F, 26'h123_4567}, 32'h100, 32'h0, 32'h0);
        repeat (3) begin
            @(negedge clk);
            chk("R10", "busy/done after unknown op", {30'd0, busy, done}, 32'd0);
        end

        // R11 issue while busy: only the first (4-word load) runs
        t_fp(0, 0, 3'b100, 5'd24, 32'h200, 16'h0030, 0, "R11");
        issue_valid = 1; issue_insn = {6'h03, 5'd6, 5'd0, 5'd7, 11'h3F0};
        base_val = 32'h0; store_val = 32'hEE;
        @(posedge clk); #1;
        @(posedge clk); #1;
        issue_valid = 0;
        t_ld(0, 0, 5'd18, 32'h3F0, 16'h0000, 0, "R11");

        repeat (8) @(posedge clk);
        chk("R9", "done pulse count", 32'(done_seen), 32'(done_exp));
        chk("R6", "memory events left", 32'(mq.size()), 32'd0);
        chk("R4", "rf events left", 32'(rq.size()), 32'd0);
        chk("R6", "fp events left", 32'(fq.size()), 32'd0);
        chk("R7", "base events left", 32'(bq.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule